// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers up to eight interrupt request lines and drives one interrupt output toward a processor. Each line can be set as edge-triggered or level-triggered. Requests collect in a request register. The controller masks them through a mask register and compares them against the lines already being serviced, which sit in an in-service register. Priority is not fixed. A stored priority base names the line that currently ranks highest, and the other lines follow in circular order from it. Rotate commands move this base, so that lines of equal importance get fair service.

Software reaches the controller through a small register port that has a two-bit select. Select 0 is the command port. A write there carries an end-of-interrupt command, a priority command or a re-initialisation. A read there is a poll: it takes the winning request without any acknowledge cycle. Select 1 is the mask, select 2 the vector base and select 3 the trigger-mode register. The processor acknowledges an interrupt with a one-cycle strobe. The controller answers with a vector formed from the vector base and the winning line number.

Top module: `pic_core`

## Requirements
- R1: After synchronous reset, the interrupt output is low and the mask, request, in-service, trigger-mode, priority-base and vector-base state all read as zero.
- R2: `intr` is high exactly when some request that is pending and not masked outranks every in-service line. It follows the registered state with no additional delay.
- R3: A line whose trigger bit (select 3, bit i = line i) is 0 latches a request on a 0-to-1 input transition. A line whose trigger bit is 1 has its request copy the input level. Both are registered on the clock edge.
- R4: The rank of line i is (i − base) mod 8, and rank 0 is the highest priority. Requests and in-service lines are both resolved by this rank.
- R5: A write to select 1 loads the mask. The new mask acts on `intr` from the next edge on, and a read of select 1 returns it.
- R6: A write to select 2 keeps only data AND 0xF8. An acknowledge of a valid request sets `ack_vector` = base | line after that edge.
- R7: A valid acknowledge sets the winning line's in-service bit. It clears that line's request only when the line is edge-triggered.
- R8: An acknowledge while `intr` is low returns the vector base | 7 and changes no state.
- R9: In a command write with data bit 4 = 0, bits 7:5 give the opcode and bits 2:0 give the line. Opcode 1 clears the highest-ranked in-service bit. Opcode 3 clears the in-service bit of the named line. Neither opcode changes the base.
- R10: Opcode 5 clears the highest-ranked in-service bit and sets base = (that line + 1) mod 8.
- R11: Opcode 6 sets base = (line + 1) mod 8. Opcode 7 clears the named in-service bit and sets base = (line + 1) mod 8.
- R12: A read of select 0 returns, one edge later, the line that would win an acknowledge. It clears that line's request and in-service bits. When nothing wins it returns 0x07.
- R13: A command write with data bit 4 = 1 clears the mask, request, in-service and base state and leaves the trigger-mode register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Interrupt request inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 command/poll, 1 mask, 2 vector base, 3 trigger mode |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid after the edge that took the read |
| inta | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | DATA_W | Vector returned by the last acknowledge |
| intr | output | 1 | Interrupt output to the processor |

## Verification
The bench builds the default configuration of eight lines and eight-bit data. At that size every one of the 256 request patterns can be tried under each of the eight priority bases. Each pattern is also mixed with a mask, and the bench predicts the winner arithmetically for every combination. Directed sequences then cover nested service, spurious acknowledges, each rotate command, poll draining and re-initialisation. These sequences use both edge-triggered and level-triggered lines.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        REG_CMD   = 2'd0,
        REG_MASK  = 2'd1,
        REG_VBASE = 2'd2,
        REG_TRIG  = 2'd3
    } pic_reg_e;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_EOI      = 3'd1,
        OP_SEOI     = 3'd3,
        OP_ROT_EOI  = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_ROT_SEOI = 3'd7
    } pic_op_e;

    localparam int CMD_INIT_BIT = 4;

    typedef struct packed {
        logic       init;
        pic_op_e    op;
        logic [2:0] line;
    } pic_cmd_t;

    function automatic pic_cmd_t decode_cmd(input logic [7:0] d);
        pic_cmd_t c;
        c.init = d[CMD_INIT_BIT];
        c.op   = pic_op_e'(d[7:5]);
        c.line = d[2:0];
        return c;
    endfunction

endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] rise
);
    logic [N_LINES-1:0] prev_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= irq_in[i];
        end
        assign rise[i] = irq_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver #(
    parameter int N_LINES = 8,
    parameter int LW      = 3
) (
    input  logic [N_LINES-1:0] vec,
    input  logic [LW-1:0]      base,
    output logic               valid,
    output logic [LW-1:0]      line,
    output logic [LW-1:0]      rank
);
    // Scan from lowest priority to highest so the last hit wins.
    always_comb begin
        valid = |vec;
        line  = '0;
        rank  = '0;
        for (int k = N_LINES - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(base) + k) % N_LINES;
            if (vec[LW'(idx)]) begin
                line = LW'(idx);
                rank = LW'(k);
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               inta,
    output logic [DATA_W-1:0]  ack_vector,
    output logic               intr
);
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam logic [DATA_W-1:0] VB_KEEP  = ~DATA_W'(N_LINES - 1);
    localparam logic [DATA_W-1:0] NO_REQ   = DATA_W'(N_LINES - 1);

    logic [N_LINES-1:0] imr_q, imr_d, irr_q, irr_d, isr_q, isr_d, trig_q, trig_d;
    logic [LW-1:0]      base_q, base_d;
    logic [DATA_W-1:0]  vbase_q, vbase_d, rd_q, rd_d, ack_q, ack_d;

    logic [N_LINES-1:0] rise, pend;
    logic               pend_valid, isr_valid, win;
    logic [LW-1:0]      pend_line, pend_rank, isr_line, isr_rank, cmd_line;
    pic_cmd_t           cmd;
    pic_reg_e           sel;

    pic_req_capture #(.N_LINES(N_LINES)) u_cap (
        .clk(clk), .rst(rst), .irq_in(irq_in), .rise(rise)
    );

    assign pend = irr_q & ~imr_q;

    pic_prio_resolver #(.N_LINES(N_LINES), .LW(LW)) u_pend_res (
        .vec(pend), .base(base_q),
        .valid(pend_valid), .line(pend_line), .rank(pend_rank)
    );

    pic_prio_resolver #(.N_LINES(N_LINES), .LW(LW)) u_isr_res (
        .vec(isr_q), .base(base_q),
        .valid(isr_valid), .line(isr_line), .rank(isr_rank)
    );

    assign win      = pend_valid && (!isr_valid || (pend_rank < isr_rank));
    assign intr     = win;
    assign cmd      = decode_cmd(wr_data[7:0]);
    assign cmd_line = cmd.line[LW-1:0];
    assign sel      = pic_reg_e'(addr);

    always_comb begin
        // request capture: level lines copy the input, edge lines accumulate
        irr_d   = (trig_q & irq_in) | (~trig_q & (irr_q | rise));
        imr_d   = imr_q;
        isr_d   = isr_q;
        trig_d  = trig_q;
        base_d  = base_q;
        vbase_d = vbase_q;
        rd_d    = rd_q;
        ack_d   = ack_q;

        if (wr_en) begin
            unique case (sel)
                REG_MASK:  imr_d   = wr_data[N_LINES-1:0];
                REG_VBASE: vbase_d = wr_data & VB_KEEP;
                REG_TRIG:  trig_d  = wr_data[N_LINES-1:0];
                REG_CMD: begin
                    if (cmd.init) begin
                        imr_d  = '0;
                        irr_d  = '0;
                        isr_d  = '0;
                        base_d = '0;
                    end else begin
                        case (cmd.op)
                            OP_EOI: begin
                                if (isr_valid) isr_d[isr_line] = 1'b0;
                            end
                            OP_ROT_EOI: begin
                                if (isr_valid) begin
                                    isr_d[isr_line] = 1'b0;
                                    base_d = isr_line + LW'(1);
                                end
                            end
                            OP_SEOI:     isr_d[cmd_line] = 1'b0;
                            OP_SET_PRIO: base_d = cmd_line + LW'(1);
                            OP_ROT_SEOI: begin
                                isr_d[cmd_line] = 1'b0;
                                base_d = cmd_line + LW'(1);
                            end
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end

        if (inta) begin
            if (win) begin
                isr_d[pend_line] = 1'b1;
                if (!trig_q[pend_line]) irr_d[pend_line] = 1'b0;
                ack_d = vbase_q | DATA_W'(pend_line);
            end else begin
                ack_d = vbase_q | NO_REQ;
            end
        end

        if (rd_en) begin
            unique case (sel)
                REG_CMD: begin
                    if (win) begin
                        irr_d[pend_line] = 1'b0;
                        isr_d[pend_line] = 1'b0;
                        rd_d = DATA_W'(pend_line);
                    end else begin
                        rd_d = NO_REQ;
                    end
                end
                REG_MASK:  rd_d = DATA_W'(imr_q);
                REG_VBASE: rd_d = vbase_q;
                REG_TRIG:  rd_d = DATA_W'(trig_q);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q   <= '0;
            irr_q   <= '0;
            isr_q   <= '0;
            trig_q  <= '0;
            base_q  <= '0;
            vbase_q <= '0;
            rd_q    <= '0;
            ack_q   <= '0;
        end else begin
            imr_q   <= imr_d;
            irr_q   <= irr_d;
            isr_q   <= isr_d;
            trig_q  <= trig_d;
            base_q  <= base_d;
            vbase_q <= vbase_d;
            rd_q    <= rd_d;
            ack_q   <= ack_d;
        end
    end

    assign rd_data    = rd_q;
    assign ack_vector = ack_q;
endmodule

// File: rtl/pic_core_checks.sv
module pic_core_checks #(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic               inta,
    input logic               intr,
    input logic [N_LINES-1:0] imr,
    input logic [N_LINES-1:0] irr,
    input logic [N_LINES-1:0] isr,
    input logic [N_LINES-1:0] trig,
    input logic [((N_LINES > 1) ? $clog2(N_LINES) : 1)-1:0] base,
    input logic [DATA_W-1:0]  vbase,
    input logic [DATA_W-1:0]  ack_vector
);
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    logic wr_cmd;
    assign wr_cmd = wr_en && (addr == 2'd0);

    assert_intr_pending_R2: assert property (@(posedge clk) disable iff (rst)
        intr |-> (|(irr & ~imr)));

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1) |=> (imr == $past(wr_data[N_LINES-1:0])));

    assert_vector_base_R6: assert property (@(posedge clk) disable iff (rst)
        inta |=> (ack_vector[DATA_W-1:LW] == $past(vbase[DATA_W-1:LW])));

    assert_ack_isr_grows_R7: assert property (@(posedge clk) disable iff (rst)
        (inta && intr && !wr_en) |=> ($countones(isr) == $countones($past(isr)) + 1));

    assert_spurious_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (inta && !intr && !wr_en) |=> (isr == $past(isr) && (&ack_vector[LW-1:0])));

    assert_set_prio_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !wr_data[4] && wr_data[7:5] == 3'd6)
            |=> (base == LW'($past(wr_data[LW-1:0]) + 1'b1)));

    assert_reinit_keeps_trig_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wr_data[4]) |=> (trig == $past(trig) && imr == '0 && isr == '0));
endmodule

bind pic_core pic_core_checks #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .inta(inta), .intr(intr), .imr(imr_q), .irr(irr_q), .isr(isr_q),
    .trig(trig_q), .base(base_q), .vbase(vbase_q), .ack_vector(ack_vector)
);

// File: tb/pic_core_tb.sv
`timescale 1ns/1ps
module pic_core_tb;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, inta = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, ack_vector;
    logic       intr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pic_core #(.N_LINES(N), .DATA_W(8)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .inta(inta),
        .ack_vector(ack_vector), .intr(intr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic ack();
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    // rank-based winner: first set line scanning from base upward, -1 if none
    function automatic int best(input logic [7:0] v, input int b);
        for (int k = 0; k < N; k++) begin
            if (v[(b + k) % N]) return (b + k) % N;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 intr", int'(intr), 0);
        rd(2'd1, r); chk("R1 mask", int'(r), 0);
        rd(2'd3, r); chk("R1 trig", int'(r), 0);
        rd(2'd2, r); chk("R1 vbase", int'(r), 0);

        // R6 vector base keeps upper bits
        wr(2'd2, 8'h4D);
        rd(2'd2, r); chk("R6 vbase read", int'(r), 8'h48);
        wr(2'd2, 8'h20);

        // R5 mask readback
        wr(2'd1, 8'hA5);
        rd(2'd1, r); chk("R5 mask read", int'(r), 8'hA5);
        wr(2'd1, 8'h00);

        // Sweep: all level lines, every base, every pattern (R2 R4 R5 R6 R7)
        wr(2'd3, 8'hFF);
        for (int b = 0; b < N; b++) begin
            wr(2'd0, 8'hC0 | 8'((b + N - 1) % N));
            for (int p = 0; p < 256; p++) begin
                logic [7:0] m;
                int w;
                m = (p % 3 == 0) ? 8'(p * 29 + b) : 8'h00;
                irq_in = 8'(p);
                wr(2'd1, m);
                w = best(8'(p) & ~m, b);
                chk("R2 R4 R5 intr", int'(intr), (w >= 0) ? 1 : 0);
                if (w >= 0) begin
                    ack();
                    chk("R4 R6 vector", int'(ack_vector), 8'h20 | w);
                    chk("R2 blocked by in-service", int'(intr), 0);
                    wr(2'd0, 8'h20);
                    chk("R7 level request kept", int'(intr), 1);
                end
                irq_in = '0;
                tick();
            end
        end
        wr(2'd1, 8'h00);

        // R3 R7 edge line
        wr(2'd0, 8'h10);
        wr(2'd3, 8'h00);
        irq_in = 8'h08; tick();
        chk("R3 edge latched", int'(intr), 1);
        ack();
        chk("R7 edge vector", int'(ack_vector), 8'h23);
        wr(2'd0, 8'h20);
        chk("R7 edge request cleared", int'(intr), 0);
        irq_in = '0; tick();
        // level line
        wr(2'd3, 8'h08);
        irq_in = 8'h08; tick();
        ack();
        wr(2'd0, 8'h20);
        chk("R7 level request kept", int'(intr), 1);
        irq_in = '0; tick();
        chk("R3 level tracks input", int'(intr), 0);

        // R8 spurious
        wr(2'd0, 8'h10);
        wr(2'd3, 8'hFF);
        ack();
        chk("R8 spurious vector", int'(ack_vector), 8'h27);
        irq_in = 8'h80; tick();
        chk("R8 no in-service set", int'(intr), 1);
        ack(); wr(2'd0, 8'h20);
        irq_in = '0; tick();

        // R9 nested service and specific EOI
        wr(2'd0, 8'h10);
        wr(2'd3, 8'h00);
        irq_in = 8'h04; tick();
        ack();
        irq_in = 8'h06; tick();
        chk("R2 nested preempt", int'(intr), 1);
        ack();
        chk("R9 nested vector", int'(ack_vector), 8'h21);
        wr(2'd0, 8'h62);
        irq_in = 8'h16; tick();
        chk("R9 line1 still in service", int'(intr), 0);
        wr(2'd0, 8'h61);
        chk("R9 specific EOI released", int'(intr), 1);
        ack();
        chk("R9 vector after EOI", int'(ack_vector), 8'h24);
        wr(2'd0, 8'h20);
        irq_in = '0; tick();

        // R10 rotate on non-specific EOI
        wr(2'd0, 8'h10);
        wr(2'd3, 8'hFF);
        irq_in = 8'h08; tick();
        ack();
        wr(2'd0, 8'hA0);
        irq_in = 8'h28; tick();
        ack();
        chk("R10 rotated winner", int'(ack_vector), 8'h25);
        wr(2'd0, 8'h20);
        irq_in = '0; tick();

        // R11 set priority and specific rotate
        wr(2'd0, 8'h10);
        wr(2'd0, 8'hC5);
        irq_in = 8'h81; tick();
        ack();
        chk("R11 set priority winner", int'(ack_vector), 8'h27);
        wr(2'd0, 8'h20);
        irq_in = 8'h0C; tick();
        ack();
        chk("R11 base 6 winner", int'(ack_vector), 8'h22);
        wr(2'd0, 8'hE2);
        chk("R11 specific rotate released", int'(intr), 1);
        ack();
        chk("R11 rotated to base 3", int'(ack_vector), 8'h23);
        wr(2'd0, 8'h20);
        irq_in = '0; tick();

        // R12 poll
        wr(2'd0, 8'h10);
        wr(2'd3, 8'h00);
        irq_in = 8'h42; tick();
        rd(2'd0, r); chk("R12 poll first", int'(r), 1);
        rd(2'd0, r); chk("R12 poll second", int'(r), 6);
        rd(2'd0, r); chk("R12 poll empty", int'(r), 7);
        chk("R12 intr after drain", int'(intr), 0);
        irq_in = '0; tick();

        // R13 reinit
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h0F);
        wr(2'd0, 8'h10);
        rd(2'd1, r); chk("R13 mask cleared", int'(r), 0);
        rd(2'd3, r); chk("R13 trig kept", int'(r), 8'h0F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule